// File: doc/BRIEF.md
# Performance Monitor Counter Unit

This block gathers execution statistics for a processor core. It holds one free-running cycle counter and a parameterised set of event counters (one to thirty-one). Each event counter chooses, through its own select field, one line from a source bus. The low part of that bus carries the core's internal event strobes. The high part carries event pulses recovered from asynchronous external inputs. Each external input goes through a two-flop synchroniser and a rising-edge detector, so a counter sees one count per change of the external signal and never counts its level.

All counters are 32 bits wide and can be loaded by software. A wrap from all ones to zero sets a sticky overflow flag. Each flag has its own interrupt enable, and one registered interrupt line reports any flag whose enable is set. The cycle counter has its own enable bit, separate from the event counter enables, and an optional divide-by-64 prescaler. A global run bit gates every counter. Software drives a single-cycle register port: a write strobe, an address and write data, with combinational read data.

Register map (7-bit word address): 0x00 control (bit0 run, bit1 divide-by-64, bit2 write-only clear of all event counters, bit3 write-only clear of the cycle counter and prescaler); 0x01 counter enables; 0x02 overflow flags (write 1 to clear); 0x03 interrupt enables; 0x04 identification (bits[4:0] = number of event counters); 0x05 cycle count; 0x20+i event count i; 0x40+i event select i. In the enable, flag and interrupt-enable words, bit 31 belongs to the cycle counter and bit i to event counter i.

Top module: `perf_count_unit`

## Requirements
- R1: After reset every counter, flag, enable, select and control bit reads 0, irq_o is 0, and address 0x04 reads NUM_EVT.
- R2: A counter advances only while the run bit (control bit0) and that counter's own enable bit are both 1; with the run bit at 0 no counter changes.
- R3: With control bit1 at 0 the cycle counter adds 1 on every clock. With bit1 at 1 it adds 1 once every 64 counting clocks, counted by a 6-bit prescaler that a cycle clear (control bit3) resets to 0.
- R4: The cycle counter's enable is bit 31 of the enable word and is independent of the event enables in bits [NUM_EVT-1:0].
- R5: Event counter i adds 1 on each clock where the source it selects is 1. Source s < EVT_W is evt_i[s], source EVT_W+j is the pulse from ext_evt_i[j], and a select of EVT_W+NUM_EXT or more counts nothing.
- R6: Each rise of ext_evt_i[j] gives exactly one count however long the input stays high. The selected counter shows it after the third rising clock edge following the change.
- R7: When a counter wraps from 0xFFFFFFFF to 0 its overflow flag is set and stays set. Writing 1 to that flag bit clears it, and writing 0 leaves it unchanged.
- R8: Writing control bit2 zeroes all event counters, and writing control bit3 zeroes the cycle counter and prescaler, at the clock edge of that write. Neither strobe touches the other counters, and both read back as 0.
- R9: irq_o is 1 on the clock after any overflow flag whose interrupt-enable bit is set is 1, and 0 on the clock after none is.
- R10: Writes to the cycle count and event count addresses load the written value, and event select i keeps its low SEL_W bits.
- R11: Bits of the enable and interrupt-enable words that belong to unbuilt counters read 0, and writes to the identification register have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| evt_i | input | EVT_W | Internal event strobes, one per source line |
| ext_evt_i | input | NUM_EXT | Asynchronous external event inputs |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 7 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i (combinational) |
| irq_o | output | 1 | Registered combined overflow interrupt |

## Verification
The properties assume that any write which changes the cycle counter comes either through the cycle count address or through the control clear bit. Each property therefore excludes exactly those writes from its antecedent and makes no assumption about how often software writes. They also assume that each level of an external input lasts long enough for the two synchronising flops to capture it. The stimulus keeps every external level for at least three clocks, changes all inputs half a period away from the active edge, and issues at most one register write per clock.

// File: rtl/pcu_pkg.sv
package pcu_pkg;
    localparam int unsigned REG_AW  = 7;
    localparam int unsigned DATA_W  = 32;
    localparam int unsigned CYC_BIT = 31;

    localparam logic [REG_AW-1:0] A_CTRL     = 7'h00;
    localparam logic [REG_AW-1:0] A_ENABLE   = 7'h01;
    localparam logic [REG_AW-1:0] A_OVF      = 7'h02;
    localparam logic [REG_AW-1:0] A_IRQEN    = 7'h03;
    localparam logic [REG_AW-1:0] A_IDENT    = 7'h04;
    localparam logic [REG_AW-1:0] A_CYCLE    = 7'h05;
    localparam logic [REG_AW-1:0] A_CNT_BASE = 7'h20;
    localparam logic [REG_AW-1:0] A_SEL_BASE = 7'h40;

    localparam int unsigned CTL_RUN   = 0;
    localparam int unsigned CTL_DIV   = 1;
    localparam int unsigned CTL_EVCLR = 2;
    localparam int unsigned CTL_CYCLR = 3;
endpackage

// File: rtl/pcu_sync_edge.sv
module pcu_sync_edge (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic async_i,
    output logic pulse_o
);
    typedef struct packed {
        logic meta;
        logic stable;
        logic prev;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d.meta   = async_i;
        sync_d.stable = sync_q.meta;
        sync_d.prev   = sync_q.stable;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= sync_d;
    end

    assign pulse_o = sync_q.stable & ~sync_q.prev;
endmodule

// File: rtl/pcu_counter.sv
module pcu_counter #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             clr_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             inc_i,
    input  logic             flag_clr_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             flag_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             flag;
    } ctr_t;

    ctr_t ctr_d, ctr_q;

    always_comb begin
        ctr_d = ctr_q;
        if (flag_clr_i) ctr_d.flag = 1'b0;
        if (clr_i) begin
            ctr_d.cnt = '0;
        end else if (load_i) begin
            ctr_d.cnt = load_val_i;
        end else if (inc_i) begin
            ctr_d.cnt = ctr_q.cnt + 1'b1;
            if (&ctr_q.cnt) ctr_d.flag = 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) ctr_q <= '0;
        else         ctr_q <= ctr_d;
    end

    assign cnt_o  = ctr_q.cnt;
    assign flag_o = ctr_q.flag;
endmodule

// File: rtl/pcu_prescale.sv
module pcu_prescale #(
    parameter int unsigned PRE_W = 6
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             clr_i,
    input  logic             step_i,
    output logic             tick_o,
    output logic [PRE_W-1:0] pre_o
);
    typedef struct packed {
        logic [PRE_W-1:0] cnt;
    } pre_t;

    pre_t pre_d, pre_q;

    always_comb begin
        pre_d = pre_q;
        if (clr_i)       pre_d.cnt = '0;
        else if (step_i) pre_d.cnt = pre_q.cnt + 1'b1;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) pre_q <= '0;
        else         pre_q <= pre_d;
    end

    assign tick_o = step_i & (&pre_q.cnt);
    assign pre_o  = pre_q.cnt;
endmodule

// File: rtl/perf_count_unit.sv
module perf_count_unit
    import pcu_pkg::*;
#(
    parameter int unsigned NUM_EVT = 4,
    parameter int unsigned EVT_W   = 8,
    parameter int unsigned NUM_EXT = 2,
    parameter int unsigned PRE_W   = 6
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic [EVT_W-1:0]    evt_i,
    input  logic [NUM_EXT-1:0]  ext_evt_i,
    input  logic                reg_wr_i,
    input  logic [REG_AW-1:0]   reg_addr_i,
    input  logic [DATA_W-1:0]   reg_wdata_i,
    output logic [DATA_W-1:0]   reg_rdata_o,
    output logic                irq_o
);
    localparam int unsigned SRC_N = EVT_W + NUM_EXT;
    localparam int unsigned SEL_W = $clog2(SRC_N);
    localparam logic [DATA_W-1:0] IMPL_MASK =
        32'h8000_0000 | ((32'd1 << NUM_EVT) - 32'd1);

    typedef struct packed {
        logic                          run;
        logic                          div;
        logic [DATA_W-1:0]             en;
        logic [DATA_W-1:0]             ie;
        logic [NUM_EVT-1:0][SEL_W-1:0] sel;
        logic                          irq;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    logic [NUM_EXT-1:0]             ext_pulse;
    logic [SRC_N-1:0]               src_vec;
    logic [NUM_EVT-1:0][DATA_W-1:0] evt_cnt;
    logic [NUM_EVT-1:0]             evt_flag;
    logic [DATA_W-1:0]              cyc_cnt;
    logic                           cyc_flag;
    logic [DATA_W-1:0]              ovf_vec;
    logic [PRE_W-1:0]               pre_cnt;
    logic                           pre_tick;
    logic                           wr_ctrl, wr_ovf, ev_clr, cy_clr, cyc_step;

    assign wr_ctrl = reg_wr_i && (reg_addr_i == A_CTRL);
    assign wr_ovf  = reg_wr_i && (reg_addr_i == A_OVF);
    assign ev_clr  = wr_ctrl && reg_wdata_i[CTL_EVCLR];
    assign cy_clr  = wr_ctrl && reg_wdata_i[CTL_CYCLR];

    // external inputs: synchronise and turn rises into single pulses
    for (genvar j = 0; j < NUM_EXT; j++) begin : g_ext
        pcu_sync_edge u_sync (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .async_i (ext_evt_i[j]),
            .pulse_o (ext_pulse[j])
        );
    end

    assign src_vec = {ext_pulse, evt_i};

    // event counters with their source selection
    for (genvar i = 0; i < NUM_EVT; i++) begin : g_evt
        logic hit;
        always_comb begin
            hit = 1'b0;
            for (int s = 0; s < SRC_N; s++) begin
                if (cfg_q.sel[i] == SEL_W'(s)) hit = src_vec[s];
            end
        end

        pcu_counter #(.CNT_W(DATA_W)) u_ctr (
            .clk_i      (clk_i),
            .rst_ni     (rst_ni),
            .clr_i      (ev_clr),
            .load_i     (reg_wr_i && (reg_addr_i == A_CNT_BASE + REG_AW'(i))),
            .load_val_i (reg_wdata_i),
            .inc_i      (cfg_q.run & cfg_q.en[i] & hit),
            .flag_clr_i (wr_ovf & reg_wdata_i[i]),
            .cnt_o      (evt_cnt[i]),
            .flag_o     (evt_flag[i])
        );
    end

    // cycle counter and its prescaler
    assign cyc_step = cfg_q.run & cfg_q.en[CYC_BIT];

    pcu_prescale #(.PRE_W(PRE_W)) u_pre (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .clr_i  (cy_clr),
        .step_i (cyc_step & cfg_q.div),
        .tick_o (pre_tick),
        .pre_o  (pre_cnt)
    );

    pcu_counter #(.CNT_W(DATA_W)) u_cyc (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .clr_i      (cy_clr),
        .load_i     (reg_wr_i && (reg_addr_i == A_CYCLE)),
        .load_val_i (reg_wdata_i),
        .inc_i      (cfg_q.div ? pre_tick : cyc_step),
        .flag_clr_i (wr_ovf & reg_wdata_i[CYC_BIT]),
        .cnt_o      (cyc_cnt),
        .flag_o     (cyc_flag)
    );

    always_comb begin
        ovf_vec          = '0;
        ovf_vec[CYC_BIT] = cyc_flag;
        for (int i = 0; i < NUM_EVT; i++) ovf_vec[i] = evt_flag[i];
    end

    // configuration registers and interrupt
    always_comb begin
        cfg_d = cfg_q;
        if (wr_ctrl) begin
            cfg_d.run = reg_wdata_i[CTL_RUN];
            cfg_d.div = reg_wdata_i[CTL_DIV];
        end
        if (reg_wr_i && (reg_addr_i == A_ENABLE)) cfg_d.en = reg_wdata_i & IMPL_MASK;
        if (reg_wr_i && (reg_addr_i == A_IRQEN))  cfg_d.ie = reg_wdata_i & IMPL_MASK;
        for (int i = 0; i < NUM_EVT; i++) begin
            if (reg_wr_i && (reg_addr_i == A_SEL_BASE + REG_AW'(i)))
                cfg_d.sel[i] = reg_wdata_i[SEL_W-1:0];
        end
        cfg_d.irq = |(ovf_vec & cfg_q.ie);
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) cfg_q <= '0;
        else         cfg_q <= cfg_d;
    end

    assign irq_o = cfg_q.irq;

    // read multiplexer
    always_comb begin
        reg_rdata_o = '0;
        case (reg_addr_i)
            A_CTRL:   reg_rdata_o = {30'd0, cfg_q.div, cfg_q.run};
            A_ENABLE: reg_rdata_o = cfg_q.en;
            A_OVF:    reg_rdata_o = ovf_vec;
            A_IRQEN:  reg_rdata_o = cfg_q.ie;
            A_IDENT:  reg_rdata_o = DATA_W'(NUM_EVT);
            A_CYCLE:  reg_rdata_o = cyc_cnt;
            default: begin
                for (int i = 0; i < NUM_EVT; i++) begin
                    if (reg_addr_i == A_CNT_BASE + REG_AW'(i)) reg_rdata_o = evt_cnt[i];
                    if (reg_addr_i == A_SEL_BASE + REG_AW'(i)) reg_rdata_o = DATA_W'(cfg_q.sel[i]);
                end
            end
        endcase
    end
endmodule

// File: rtl/pcu_checker.sv
module pcu_checker
    import pcu_pkg::*;
#(
    parameter int unsigned PRE_W = 6
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              reg_wr_i,
    input logic [REG_AW-1:0] reg_addr_i,
    input logic [DATA_W-1:0] reg_wdata_i,
    input logic              run,
    input logic              div,
    input logic              cyc_en,
    input logic [DATA_W-1:0] cyc_cnt,
    input logic              cyc_flag,
    input logic [PRE_W-1:0]  pre_cnt,
    input logic [DATA_W-1:0] ovf_vec,
    input logic [DATA_W-1:0] ie,
    input logic              irq_o
);
    logic cyc_clr_wr, cyc_touch, cyc_flag_wr;

    assign cyc_clr_wr  = reg_wr_i && (reg_addr_i == A_CTRL) && reg_wdata_i[CTL_CYCLR];
    assign cyc_touch   = cyc_clr_wr || (reg_wr_i && (reg_addr_i == A_CYCLE));
    assign cyc_flag_wr = reg_wr_i && (reg_addr_i == A_OVF) && reg_wdata_i[CYC_BIT];

    // R2
    run_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!run && !cyc_touch) |=> $stable(cyc_cnt));

    // R4
    cyc_enable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!cyc_en && !cyc_touch) |=> $stable(cyc_cnt));

    // R3
    per_clock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run && cyc_en && !div && !cyc_touch) |=> (cyc_cnt == $past(cyc_cnt) + 32'd1));

    // R3
    div_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run && cyc_en && div && (pre_cnt != '1) && !cyc_touch) |=> $stable(cyc_cnt));

    // R8
    cyc_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cyc_clr_wr |=> ((cyc_cnt == '0) && (pre_cnt == '0)));

    // R7
    flag_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cyc_flag && !cyc_flag_wr) |=> cyc_flag);

    // R9
    irq_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|(ovf_vec & ie)) |=> irq_o);

    // R9
    irq_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((ovf_vec & ie) == '0) |=> !irq_o);
endmodule

bind perf_count_unit pcu_checker #(.PRE_W(PRE_W)) i_pcu_checker (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .reg_wr_i    (reg_wr_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .run         (cfg_q.run),
    .div         (cfg_q.div),
    .cyc_en      (cfg_q.en[pcu_pkg::CYC_BIT]),
    .cyc_cnt     (cyc_cnt),
    .cyc_flag    (cyc_flag),
    .pre_cnt     (pre_cnt),
    .ovf_vec     (ovf_vec),
    .ie          (cfg_q.ie),
    .irq_o       (irq_o)
);

// File: tb/test_perf_count_unit.sv
module test_perf_count_unit;
    localparam int NUM_EVT = 4;
    localparam int EVT_W   = 8;
    localparam int NUM_EXT = 2;

    localparam logic [6:0] A_CTRL = 7'h00, A_EN = 7'h01, A_OVF = 7'h02, A_IE = 7'h03,
                           A_ID = 7'h04, A_CYC = 7'h05, A_CNT = 7'h20, A_SEL = 7'h40;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [EVT_W-1:0]   evt = '0;
    logic [NUM_EXT-1:0] ext = '0;
    logic               wr = 1'b0;
    logic [6:0]         addr = '0;
    logic [31:0]        wdata = '0;
    logic [31:0]        rdata;
    logic               irq;

    int total = 0;
    int bad   = 0;
    logic [31:0] v;

    always #5 clk = ~clk;

    perf_count_unit #(.NUM_EVT(NUM_EVT), .EVT_W(EVT_W), .NUM_EXT(NUM_EXT)) i_perf_count_unit (
        .clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .ext_evt_i(ext),
        .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wdata),
        .reg_rdata_o(rdata), .irq_o(irq)
    );

    // {address, write data, expected read-back}
    localparam int NV = 10;
    localparam logic [70:0] VEC [NV] = '{
        {A_EN,       32'hFFFF_FFFF, 32'h8000_000F},  // R11
        {A_IE,       32'hFFFF_FFFF, 32'h8000_000F},  // R11
        {A_ID,       32'h0000_001F, 32'h0000_0004},  // R11
        {A_CTRL,     32'h0000_00F2, 32'h0000_0002},
        {A_CTRL,     32'h0000_0000, 32'h0000_0000},
        {A_SEL,      32'h0000_00FF, 32'h0000_000F},  // R10
        {A_CNT + 1,  32'hA5A5_5A5A, 32'hA5A5_5A5A},  // R10
        {A_CYC,      32'h1234_5678, 32'h1234_5678},  // R10
        {A_EN,       32'h0000_0000, 32'h0000_0000},
        {A_IE,       32'h0000_0000, 32'h0000_0000}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // starts and ends at a falling edge
    task automatic wreg(input logic [6:0] a, input logic [31:0] d);
        wr = 1'b1; addr = a; wdata = d;
        @(posedge clk);
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic rreg(input logic [6:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    // run for k+1 counting edges, then stop
    task automatic run(input logic [31:0] ctl, input int k);
        wreg(A_CTRL, ctl);
        repeat (k) @(negedge clk);
        wreg(A_CTRL, 32'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // reset state
        check("R1 irq", {31'd0, irq}, 32'h0);
        rreg(A_CTRL, v); check("R1 ctrl", v, 32'h0);
        rreg(A_EN, v);   check("R1 enable", v, 32'h0);
        rreg(A_OVF, v);  check("R1 flags", v, 32'h0);
        rreg(A_CYC, v);  check("R1 cycle", v, 32'h0);
        rreg(A_CNT, v);  check("R1 count0", v, 32'h0);
        rreg(A_ID, v);   check("R1 ident", v, 32'd4);

        // register round trips
        for (int n = 0; n < NV; n++) begin
            wreg(VEC[n][70:64], VEC[n][63:32]);
            rreg(VEC[n][70:64], v);
            check("R10/R11 table", v, VEC[n][31:0]);
        end

        // clear strobes
        wreg(A_CYC, 32'h55);
        wreg(A_CTRL, 32'h4);
        rreg(A_CNT + 1, v); check("R8 event clear", v, 32'h0);
        rreg(A_CYC, v);     check("R8 cycle untouched", v, 32'h55);
        rreg(A_CTRL, v);    check("R8 strobes read 0", v, 32'h0);
        wreg(A_CTRL, 32'h8);
        rreg(A_CYC, v);     check("R8 cycle clear", v, 32'h0);

        // cycle counting per clock
        wreg(A_EN, 32'h8000_0000);
        run(32'h1, 10);
        rreg(A_CYC, v); check("R3 per clock", v, 32'd11);
        repeat (5) @(negedge clk);
        rreg(A_CYC, v); check("R2 run off", v, 32'd11);
        wreg(A_EN, 32'h0000_000F);
        run(32'h1, 5);
        rreg(A_CYC, v); check("R4 cycle enable off", v, 32'd11);

        // divide by 64
        wreg(A_CTRL, 32'h8);
        wreg(A_EN, 32'h8000_0000);
        run(32'h3, 127);
        rreg(A_CYC, v); check("R3 div 128 clocks", v, 32'd2);
        run(32'h3, 99);
        rreg(A_CYC, v); check("R3 div 100 clocks", v, 32'd3);
        wreg(A_CTRL, 32'h8);
        run(32'h3, 29);
        rreg(A_CYC, v); check("R3 prescaler cleared", v, 32'd0);

        // event selection
        wreg(A_CTRL, 32'h4);
        wreg(A_SEL + 0, 32'd3);
        wreg(A_SEL + 1, 32'd3);
        wreg(A_SEL + 2, 32'd12);
        wreg(A_SEL + 3, 32'd8);
        wreg(A_EN, 32'h0000_000D);
        wreg(A_CTRL, 32'h1);
        for (int t = 0; t < 10; t++) begin
            evt = ((10'b1011001110 >> t) & 1) != 0 ? 8'h08 : 8'hF7;
            @(negedge clk);
        end
        evt = '0;
        wreg(A_CTRL, 32'h0);
        rreg(A_CNT + 0, v); check("R5 select 3", v, 32'd6);
        rreg(A_CNT + 1, v); check("R2 counter disabled", v, 32'd0);
        rreg(A_CNT + 2, v); check("R5 select out of range", v, 32'd0);
        rreg(A_CNT + 3, v); check("R5 ext source idle", v, 32'd0);
        wreg(A_SEL + 0, 32'd0);
        wreg(A_CTRL, 32'h1);
        evt = 8'h01;
        repeat (4) @(negedge clk);
        evt = '0;
        wreg(A_CTRL, 32'h0);
        rreg(A_CNT + 0, v); check("R5 select 0", v, 32'd10);

        // external edges
        wreg(A_CTRL, 32'h4);
        wreg(A_SEL + 2, 32'd9);
        wreg(A_EN, 32'h0000_000C);
        wreg(A_CTRL, 32'h1);
        ext[0] = 1'b1;
        repeat (2) @(negedge clk);
        rreg(A_CNT + 3, v); check("R6 not before third edge", v, 32'd0);
        @(negedge clk);
        rreg(A_CNT + 3, v); check("R6 third edge", v, 32'd1);
        repeat (15) @(negedge clk);
        rreg(A_CNT + 3, v); check("R6 level ignored", v, 32'd1);
        ext[0] = 1'b0;
        repeat (4) @(negedge clk);
        ext = 2'b11;
        repeat (4) @(negedge clk);
        ext = 2'b00;
        repeat (4) @(negedge clk);
        wreg(A_CTRL, 32'h0);
        rreg(A_CNT + 3, v); check("R6 two rises", v, 32'd2);
        rreg(A_CNT + 2, v); check("R6 ext1 one rise", v, 32'd1);

        // overflow and interrupt
        wreg(A_CTRL, 32'h4);
        wreg(A_CNT + 0, 32'hFFFF_FFFE);
        wreg(A_SEL + 0, 32'd3);
        wreg(A_EN, 32'h0000_0001);
        wreg(A_IE, 32'h0000_0001);
        evt = 8'h08;
        run(32'h1, 1);
        evt = '0;
        rreg(A_CNT + 0, v); check("R7 wrapped", v, 32'h0);
        rreg(A_OVF, v);     check("R7 flag set", v, 32'h1);
        check("R9 irq not yet", {31'd0, irq}, 32'h0);
        @(negedge clk);
        check("R9 irq raised", {31'd0, irq}, 32'h1);
        wreg(A_OVF, 32'h0);
        rreg(A_OVF, v);     check("R7 write 0 keeps flag", v, 32'h1);
        wreg(A_OVF, 32'h1);
        rreg(A_OVF, v);     check("R7 write 1 clears", v, 32'h0);
        @(negedge clk);
        check("R9 irq dropped", {31'd0, irq}, 32'h0);

        wreg(A_CTRL, 32'h8);
        wreg(A_CYC, 32'hFFFF_FFFF);
        wreg(A_EN, 32'h8000_0000);
        run(32'h1, 0);
        rreg(A_OVF, v); check("R7 cycle flag", v, 32'h8000_0000);
        repeat (2) @(negedge clk);
        check("R9 masked flag", {31'd0, irq}, 32'h0);
        wreg(A_IE, 32'h8000_0001);
        @(negedge clk);
        check("R9 enable after flag", {31'd0, irq}, 32'h1);
        wreg(A_OVF, 32'hFFFF_FFFF);
        rreg(A_OVF, v); check("R7 clear all", v, 32'h0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule